// File: doc/BRIEF.md
# Two-Stage Linear Horizontal Line Scaler

This block changes the number of luma samples on a video line. Pixels pass through two linear-interpolation stages in series. The first stage can only reduce the sample count and the second can only increase it. Each stage is driven by a fixed-point step, the distance in input pixels between two output positions, with 10 fractional bits. Each output pixel is a blend of its two neighbouring input pixels. The weight is the top four fractional bits of the stage's phase, and the result is rounded. A programmable luma offset is added to every result, and the sum saturates at the top of the pixel range.

Software writes a step for each stage, a line length and an offset into holding registers. These values do not touch the datapath when they are written. They are copied into the working registers only after software writes the control word with its commit bit low, and the copy waits for the next accepted line-start pixel. The commit bit reads back low while the copy is outstanding and returns high once the new values are in use. Pixels enter and leave on valid/ready streams, and each stream carries a flag on the first pixel of a line.

Top module: `hscl_top`

## Requirements
- R1: After reset the control word reads 0x800 (commit bit 11 set, mode 0), both steps are 1024, the line length is 1080 and the offset is 57. With these values, a line of n pixels produces the n-2 outputs x[0..n-3], each plus 57.
- R2: Compressor step register (address 1): output k of stage one is taken at input position p = k*S1/1024, with b = p>>10 and w = bits [9:6] of p. The output is (x[b]*(16-w) + x[b+1]*w + 8)>>4, produced while b+1 is below the line's pixel count.
- R3: Expander step register (address 2): stage two applies the same position rule with step S2 to the stage-one samples, producing several outputs between two neighbouring samples when S2 < 1024.
- R4: The two stages run in series on every line, so compression and expansion combine in one pass.
- R5: Offset register (address 4, 7 bits): the offset is added to every stage-two result, and sums above 255 are output as 255.
- R6: Line length register (address 3): after a line-start pixel, only the first L pixels of the line (the start pixel included) are used. Later pixels, and any pixel before the first line start, are accepted and discarded.
- R7: Writes to addresses 1 to 4 change nothing on the datapath until a commit has been applied.
- R8: Control word at address 0: writing it with bit 11 = 0 requests a commit, and bit 11 reads 0 until the next accepted line-start pixel. That line uses the new values and bit 11 then reads 1. Writing it with bit 11 = 1 stores the mode and commits nothing. The control word changes only on a write or on a line start.
- R9: On commit, a compressor step below 1024 becomes 1024, and an expander step below 256 or above 1024 is limited to 256 or 1024.
- R10: Control word bits [1:0] hold the mode and read back as written. Bits [10:2] always read 0. All four mode values scale linearly.
- R11: The first output of each line has out_sol set and all other outputs have it clear. While out_valid is high and out_ready is low, the output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 control, 1 compress step, 2 expand step, 3 length, 4 offset) |
| cfg_wdata | input | 12 | Register write data |
| mode_rd | output | 12 | Control word readback: bit 11 commit done, bits [1:0] mode |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 8 | Input luma pixel |
| in_sol | input | 1 | Input pixel is first of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 8 | Scaled luma pixel with offset |
| out_sol | output | 1 | Output pixel is first of a line |

## Verification
The assertions check the commit handshake on every cycle. They confirm that a request clears bit 11, that bit 11 rises only after a line start is accepted, and that the control word is otherwise steady. They also check that both working steps stay within range and that a stalled output holds. The sample values need the bench's scenarios. These cover the interpolation weights and rounding, how the two stages combine, saturation at 255, pixels discarded beyond the line length, and holding values that wait for a commit.

// File: rtl/hscl_pkg.sv
// Shared definitions for the horizontal line scaler.
// Assumes a 3-bit register address; the top casts to its own width.
package hscl_pkg;
    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_CSTEP = 3'd1,
        REG_ESTEP = 3'd2,
        REG_LEN   = 3'd3,
        REG_OFS   = 3'd4
    } hscl_reg_e;

    typedef enum logic [1:0] {
        MODE_LINEAR = 2'd0,
        MODE_WIDE   = 2'd1,
        MODE_CURVED = 2'd2,
        MODE_SPARE  = 2'd3
    } hscl_mode_e;
endpackage

// File: rtl/hscl_lerp.sv
// Two-point linear blend with round-half-up.
// Assumes the weight has WGT_W bits, with weight 0 selecting input a.
module hscl_lerp #(
    parameter int PIX_W = 8,
    parameter int WGT_W = 4
) (
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    input  logic [WGT_W-1:0] w,
    output logic [PIX_W-1:0] y
);
    localparam int SW = PIX_W + WGT_W + 1;

    logic [WGT_W:0]  wa;
    logic [SW-1:0]   sum;

    // weighted sum of both neighbours plus half an LSB, then scale down
    always_comb begin
        wa  = (WGT_W+1)'(1 << WGT_W) - {1'b0, w};
        sum = SW'(a) * SW'(wa) + SW'(b) * SW'({1'b0, w}) + SW'(1 << (WGT_W-1));
        y   = sum[WGT_W +: PIX_W];
    end
endmodule

// File: rtl/hscl_stage.sv
// One resampling stage. It holds a pair of neighbouring pixels and a phase
// measured from the left pixel of the pair. It emits one blended output
// while the phase is below one pixel and advances the phase by the step.
// When the phase is one pixel or more it takes a new pixel and subtracts one.
// The step and a sideband word are latched when a line-start pixel arrives.
// Assumes step < 4 pixels, so the phase never exceeds ACC_W bits.
module hscl_stage #(
    parameter int PIX_W  = 8,
    parameter int STEP_W = 12,
    parameter int FRAC_W = 10,
    parameter int ACC_W  = 22,
    parameter int WGT_W  = 4,
    parameter int SIDE_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_in,
    input  logic [SIDE_W-1:0] side_in,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_data,
    input  logic              in_sol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data,
    output logic              out_sol,
    output logic [SIDE_W-1:0] side_out
);
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

    logic [1:0]        cnt;
    logic [PIX_W-1:0]  prv, cur;
    logic [ACC_W-1:0]  rel;
    logic              first;
    logic [STEP_W-1:0] step_l;
    logic [SIDE_W-1:0] side_l;
    logic              pair_ok, at_pos;

    assign pair_ok   = (cnt == 2'd2);
    assign at_pos    = (rel < ONE);
    assign out_valid = pair_ok && at_pos;
    assign in_ready  = !(pair_ok && at_pos);
    assign out_sol   = first;
    assign side_out  = side_l;

    hscl_lerp #(.PIX_W(PIX_W), .WGT_W(WGT_W)) lerp_i (
        .a(prv), .b(cur), .w(rel[FRAC_W-1 -: WGT_W]), .y(out_data)
    );

    // pixel pair, phase and per-line settings update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; prv <= '0; cur <= '0; rel <= '0;
            first <= 1'b0; step_l <= '0; side_l <= '0;
        end else if (in_valid && in_ready) begin
            if (in_sol) begin
                cur <= in_data; cnt <= 2'd1; rel <= '0; first <= 1'b1;
                step_l <= step_in; side_l <= side_in;
            end else if (cnt != 2'd0) begin
                prv <= cur; cur <= in_data; cnt <= 2'd2;
                if (cnt == 2'd2) rel <= rel - ONE;
            end
        end else if (out_valid && out_ready) begin
            rel   <= rel + ACC_W'(step_l);
            first <= 1'b0;
        end
    end
endmodule

// File: rtl/hscl_top.sv
// Two-stage linear horizontal scaler with holding registers and a commit
// handshake. Settings written by software are copied into working registers
// at the first accepted line start after a commit request. The settings for
// one line then travel with that line through both stages.
// Assumes a line start is always flagged on its first pixel.
module hscl_top
    import hscl_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int STEP_W  = 12,
    parameter int FRAC_W  = 10,
    parameter int ACC_W   = 22,
    parameter int WGT_W   = 4,
    parameter int OFF_W   = 7,
    parameter int LEN_W   = 12,
    parameter int ADDR_W  = 3,
    parameter int DEF_LEN = 1080,
    parameter int DEF_OFF = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [STEP_W-1:0] cfg_wdata,
    output logic [STEP_W-1:0] mode_rd,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_data,
    input  logic              in_sol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data,
    output logic              out_sol
);
    localparam logic [STEP_W-1:0] S_ONE  = STEP_W'(1) << FRAC_W;
    localparam logic [STEP_W-1:0] S2_MIN = STEP_W'(1) << (FRAC_W - 2);
    localparam int SIDE1_W = STEP_W + OFF_W;
    localparam logic [PIX_W:0] PIX_MAX = {1'b0, {PIX_W{1'b1}}};

    // step limits applied on commit
    function automatic logic [STEP_W-1:0] lim_c(input logic [STEP_W-1:0] v);
        return (v < S_ONE) ? S_ONE : v;
    endfunction
    function automatic logic [STEP_W-1:0] lim_e(input logic [STEP_W-1:0] v);
        return (v < S2_MIN) ? S2_MIN : ((v > S_ONE) ? S_ONE : v);
    endfunction

    logic [STEP_W-1:0] sh_s1, sh_s2, act_s1, act_s2, nxt_s1, nxt_s2;
    logic [LEN_W-1:0]  sh_len, act_len, nxt_len, len_l, pix_cnt;
    logic [OFF_W-1:0]  sh_off, act_off, nxt_off;
    hscl_mode_e        mode_q;
    logic              pending, line_open, drop, sol_acc;

    assign nxt_s1  = pending ? lim_c(sh_s1) : act_s1;
    assign nxt_s2  = pending ? lim_e(sh_s2) : act_s2;
    assign nxt_len = pending ? sh_len : act_len;
    assign nxt_off = pending ? sh_off : act_off;
    assign mode_rd = {~pending, {(STEP_W-3){1'b0}}, mode_q};

    assign drop    = !in_sol && !(line_open && pix_cnt < len_l);
    assign sol_acc = in_valid && in_ready && in_sol;

    // register writes, commit request and commit at line start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_s1 <= S_ONE; sh_s2 <= S_ONE; sh_len <= LEN_W'(DEF_LEN); sh_off <= OFF_W'(DEF_OFF);
            act_s1 <= S_ONE; act_s2 <= S_ONE; act_len <= LEN_W'(DEF_LEN); act_off <= OFF_W'(DEF_OFF);
            mode_q <= MODE_LINEAR; pending <= 1'b0;
        end else begin
            if (sol_acc && pending) begin
                act_s1 <= nxt_s1; act_s2 <= nxt_s2; act_len <= nxt_len; act_off <= nxt_off;
                pending <= 1'b0;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    ADDR_W'(REG_CTRL): begin
                        mode_q <= hscl_mode_e'(cfg_wdata[1:0]);
                        if (!cfg_wdata[STEP_W-1]) pending <= 1'b1;
                    end
                    ADDR_W'(REG_CSTEP): sh_s1  <= cfg_wdata;
                    ADDR_W'(REG_ESTEP): sh_s2  <= cfg_wdata;
                    ADDR_W'(REG_LEN):   sh_len <= LEN_W'(cfg_wdata);
                    ADDR_W'(REG_OFS):   sh_off <= cfg_wdata[OFF_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // pixel count within the current line, for the length limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_open <= 1'b0; pix_cnt <= '0; len_l <= '0;
        end else if (sol_acc) begin
            line_open <= 1'b1; pix_cnt <= LEN_W'(1); len_l <= nxt_len;
        end else if (in_valid && in_ready && !drop) begin
            pix_cnt <= pix_cnt + LEN_W'(1);
        end
    end

    logic              s1_in_ready, s1_valid, s1_sol, s2_ready;
    logic [PIX_W-1:0]  s1_data, s2_data;
    logic [SIDE1_W-1:0] s1_side;
    logic [OFF_W-1:0]  s2_off;
    logic [PIX_W:0]    sum;

    assign in_ready = drop || s1_in_ready;

    hscl_stage #(.PIX_W(PIX_W), .STEP_W(STEP_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W),
                 .WGT_W(WGT_W), .SIDE_W(SIDE1_W)) cmp_i (
        .clk(clk), .rst_n(rst_n), .step_in(nxt_s1), .side_in({nxt_s2, nxt_off}),
        .in_valid(in_valid && !drop), .in_ready(s1_in_ready), .in_data(in_data), .in_sol(in_sol),
        .out_valid(s1_valid), .out_ready(s2_ready), .out_data(s1_data), .out_sol(s1_sol),
        .side_out(s1_side)
    );

    hscl_stage #(.PIX_W(PIX_W), .STEP_W(STEP_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W),
                 .WGT_W(WGT_W), .SIDE_W(OFF_W)) exp_i (
        .clk(clk), .rst_n(rst_n), .step_in(s1_side[SIDE1_W-1:OFF_W]), .side_in(s1_side[OFF_W-1:0]),
        .in_valid(s1_valid), .in_ready(s2_ready), .in_data(s1_data), .in_sol(s1_sol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(s2_data), .out_sol(out_sol),
        .side_out(s2_off)
    );

    // add the offset and saturate at full scale
    always_comb begin
        sum      = {1'b0, s2_data} + (PIX_W+1)'(s2_off);
        out_data = (sum > PIX_MAX) ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
    end
endmodule

// File: rtl/hscl_chk.sv
// Property checker for hscl_top, attached with bind. It observes the
// commit handshake, the working step ranges and output stall behaviour.
module hscl_chk #(
    parameter int STEP_W = 12,
    parameter int FRAC_W = 10,
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [STEP_W-1:0] cfg_wdata,
    input logic [STEP_W-1:0] mode_rd,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sol,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PIX_W-1:0]  out_data,
    input logic              out_sol,
    input logic [STEP_W-1:0] act_s1,
    input logic [STEP_W-1:0] act_s2
);
    localparam logic [STEP_W-1:0] S_ONE  = STEP_W'(1) << FRAC_W;
    localparam logic [STEP_W-1:0] S2_MIN = STEP_W'(1) << (FRAC_W - 2);

    logic ctrl_wr, sol_acc;
    assign ctrl_wr = cfg_we && (cfg_addr == '0);
    assign sol_acc = in_valid && in_ready && in_sol;

    a_r8_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !cfg_wdata[STEP_W-1] |=> !mode_rd[STEP_W-1]);

    a_r8_done_after_sol: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_rd[STEP_W-1]) |-> $past(sol_acc));

    a_r8_ctrl_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr && !sol_acc |=> $stable(mode_rd));

    a_r9_cstep_range: assert property (@(posedge clk) disable iff (!rst_n)
        act_s1 >= S_ONE);

    a_r9_estep_range: assert property (@(posedge clk) disable iff (!rst_n)
        act_s2 >= S2_MIN && act_s2 <= S_ONE);

    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sol));
endmodule

bind hscl_top hscl_chk #(.STEP_W(STEP_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mode_rd(mode_rd), .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sol(out_sol),
    .act_s1(act_s1), .act_s2(act_s2)
);

// File: tb/hscl_top_tb_top.sv
module hscl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] mode_rd;
    logic        in_valid = 1'b0, in_ready, in_sol = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_ready = 1'b0, out_sol;
    logic [7:0]  out_data;

    always #2 clk = ~clk;

    hscl_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mode_rd(mode_rd), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sol(in_sol), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sol(out_sol)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    int xs[4096], ys[4096], zs[4096];
    int eff_s1 = 1024, eff_s2 = 1024, eff_len = 1080, eff_off = 57;

    // vector: [63:52] s1, [51:40] s2, [39:28] len, [27:20] off, [19:8] npix, [7:0] seed
    localparam int NV = 8;
    localparam logic [63:0] VECS [NV] = '{
        {12'd1024, 12'd1024, 12'd40,  8'd0,   12'd40,  8'd3},   // R4 plain pass
        {12'd1536, 12'd1024, 12'd64,  8'd5,   12'd64,  8'd17},  // R2 compress 1.5
        {12'd1024, 12'd683,  12'd30,  8'd10,  12'd30,  8'd29},  // R3 expand 1.5
        {12'd2048, 12'd512,  12'd50,  8'd0,   12'd50,  8'd41},  // R4 both stages
        {12'd4095, 12'd256,  12'd100, 8'd127, 12'd100, 8'd53},  // R5 saturation
        {12'd1024, 12'd1024, 12'd20,  8'd3,   12'd35,  8'd61},  // R6 length limit
        {12'd100,  12'd100,  12'd16,  8'd0,   12'd16,  8'd73},  // R9 low steps
        {12'd1300, 12'd1500, 12'd33,  8'd1,   12'd33,  8'd89}   // R9 high expand step
    };

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pix(input int seed, input int i);
        return (seed * 37 + i * (seed + 11) + (i * i) % 53) & 255;
    endfunction

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 12'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one line and compare the outputs with the model of R2..R6 and R11.
    task automatic run_line(input int npix, input int seed, input string req);
        int n, n1, n2, got, to, extra;
        for (int i = 0; i < npix; i++) xs[i] = pix(seed, i);
        n = (npix < eff_len) ? npix : eff_len;
        n1 = 0;
        for (int k = 0; k < 4096; k++) begin
            int p, b, w;
            p = k * eff_s1; b = p >> 10; w = (p >> 6) & 15;
            if (b + 2 > n) break;
            ys[n1] = (xs[b] * (16 - w) + xs[b + 1] * w + 8) >> 4;
            n1++;
        end
        n2 = 0;
        for (int k = 0; k < 4096; k++) begin
            int p, b, w, v;
            p = k * eff_s2; b = p >> 10; w = (p >> 6) & 15;
            if (b + 2 > n1) break;
            v = ((ys[b] * (16 - w) + ys[b + 1] * w + 8) >> 4) + eff_off;
            zs[n2] = (v > 255) ? 255 : v;
            n2++;
        end
        got = 0; to = 0;
        fork
            begin
                for (int i = 0; i < npix; i++) begin
                    @(negedge clk);
                    in_valid = 1'b1; in_sol = (i == 0); in_data = 8'(xs[i]);
                    #1;
                    while (!in_ready) begin @(negedge clk); #1; end
                end
                @(negedge clk);
                in_valid = 1'b0; in_sol = 1'b0;
            end
            begin
                while (got < n2 && to < 20000) begin
                    @(negedge clk);
                    to++;
                    out_ready = ((cyc % 5) != 3);
                    if (out_valid && out_ready) begin
                        chk(int'(out_data) == zs[got], req, "sample value", int'(out_data), zs[got]);
                        chk(out_sol == (got == 0), "R11", "line-start flag", int'(out_sol), int'(got == 0));
                        got++;
                    end
                end
            end
        join
        chk(got == n2, req, "output count", got, n2);
        extra = 0;
        repeat (30) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) extra++;
        end
        chk(extra == 0, req, "surplus outputs", extra, 0);
    endtask

    function automatic int lim_c(input int v);
        return (v < 1024) ? 1024 : v;
    endfunction
    function automatic int lim_e(input int v);
        return (v < 256) ? 256 : ((v > 1024) ? 1024 : v);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R10 reset readback
        chk(mode_rd == 12'h800, "R1", "control word after reset", int'(mode_rd), 'h800);

        // R6 pixels before any line start are discarded
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sol = 1'b0; in_data = 8'(200 + i);
            #1;
            if (!in_ready) seen++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (20) begin @(negedge clk); if (out_valid) seen++; end
        chk(seen == 0, "R6", "pre-start pixels stalled or emitted", seen, 0);

        // R1 default settings on a short line
        run_line(10, 9, "R1");

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            int md, wr;
            v = VECS[i];
            cfg_write(1, int'(v[63:52]));
            cfg_write(2, int'(v[51:40]));
            cfg_write(3, int'(v[39:28]));
            cfg_write(4, int'(v[27:20]));
            md = i % 4;
            wr = (i % 2 == 1) ? ('h7FC | md) : md;
            cfg_write(0, wr);
            // R8 R10 request pending, mode readback, reserved bits zero
            chk(mode_rd == 12'(md), "R8", "control word after commit request", int'(mode_rd), md);
            eff_s1 = lim_c(int'(v[63:52])); eff_s2 = lim_e(int'(v[51:40]));
            eff_len = int'(v[39:28]); eff_off = int'(v[27:20]);
            run_line(int'(v[19:8]), int'(v[7:0]), (i == 6 || i == 7) ? "R9" : (i == 1 ? "R2" : (i == 2 ? "R3" : (i == 4 ? "R5" : (i == 5 ? "R6" : "R4")))));
            chk(mode_rd == 12'(12'h800 | md), "R8", "commit done after line start", int'(mode_rd), 'h800 | md);
        end

        // R7 holding writes without a commit leave the datapath unchanged
        cfg_write(1, 2048);
        cfg_write(4, 0);
        run_line(33, 101, "R7");

        // R8 control write with bit 11 set stores mode only
        cfg_write(0, 'h801);
        chk(mode_rd == 12'h801, "R10", "mode readback without commit", int'(mode_rd), 'h801);
        run_line(33, 113, "R8");

        // R8 request stays pending until a line start
        cfg_write(0, 'h002);
        repeat (10) @(negedge clk);
        chk(mode_rd == 12'h002, "R8", "pending without line start", int'(mode_rd), 'h002);
        eff_s1 = 2048; eff_off = 0;
        run_line(33, 127, "R7");
        chk(mode_rd == 12'h802, "R8", "commit done", int'(mode_rd), 'h802);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule